// File: doc/BRIEF.md
# CAN Clock Prescaler Chain

This block turns one base clock into three slower rates for a CAN controller subsystem. It does not make new clock nets. Each rate comes out as an enable pulse that lasts one base-clock cycle. The three rates are the memory-controller rate, the global-timer rate and the system-timer tick. The stages form a cascade, and each stage counts only the enable pulses of the stage before it.

- **Memory stage.** A programmable divide-by-(n+1) driven by the base clock.
- **Global-timer stage.** Selects a division of the memory rate by 2, 4, 8 or 16.
- **System-timer stage.** A second programmable divide-by-(n+1) driven by the global-timer pulses.

All three settings are held in one configuration word, which a single write strobe loads.

The two programmable stages each run a two-state machine:

- **DIV_PASS:** the divisor is zero, so input pulses are forwarded unchanged.
- **DIV_COUNT:** the stage counts input pulses up to the divisor.

The transition between the two states happens only at a terminal count. At that point the stage reloads the divisor and picks DIV_PASS when the new value is zero, or DIV_COUNT otherwise.

The power-of-two stage has four states: GT_DIV2, GT_DIV4, GT_DIV8 and GT_DIV16. It moves to the state named by the select field only when its current count ends.

Top module: `canclk_chain`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the configuration and every counter. In the cycles after reset the memory enable is high every cycle, the global-timer enable is high every second cycle, and the system-timer enable equals the global-timer enable.
- R2: When wr_en is high at a clock edge, the configuration is loaded from wr_data: bits [3:0] hold the memory divisor, bits [5:4] hold the global-timer select, and bits [13:6] hold the system-timer divisor.
- R3: With memory divisor n (0 to 15), mem_en pulses once every n+1 base-clock cycles.
- R4: Global-timer select codes 0, 1, 2 and 3 make gt_en pulse once every 2, 4, 8 and 16 mem_en pulses respectively.
- R5: With system-timer divisor m (0 to 255), sys_en pulses once every m+1 gt_en pulses.
- R6: gt_en is high only in cycles where mem_en is high, and sys_en is high only in cycles where gt_en is high.
- R7: A new divisor written in the middle of a stage's period does not shorten or stretch that period. The new value takes effect starting with the next period.
- R8: A programmable stage whose divisor is zero passes each input pulse through in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base CAN clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 14 | Configuration word: system divisor, select, memory divisor |
| mem_en | output | 1 | Memory-controller rate enable pulse |
| gt_en | output | 1 | Global-timer rate enable pulse |
| sys_en | output | 1 | System-timer tick enable pulse |

## Verification
The bench measures pulse spacing on each output for several configurations, including the largest system divisor and the largest memory divisor. A design that swapped or shifted the fields, or divided by n instead of n+1, would give the wrong spacing.

It rewrites the memory divisor partway through a period and expects the current period to keep its old length. A design that reloads immediately would produce one short or long period.

It checks the state after reset and after a reset applied mid-run. It also confirms that the outputs nest within each other in every sampled cycle. A stage that ran on the base clock rather than on its input enable would break that nesting.

// File: rtl/canclk_pkg.sv
package canclk_pkg;
    localparam int MEM_DIV_W = 4;
    localparam int GT_SEL_W  = 2;
    localparam int SYS_DIV_W = 8;

    typedef enum logic {
        DIV_PASS,
        DIV_COUNT
    } div_state_t;

    typedef enum logic [1:0] {
        GT_DIV2  = 2'd0,
        GT_DIV4  = 2'd1,
        GT_DIV8  = 2'd2,
        GT_DIV16 = 2'd3
    } gt_state_t;
endpackage

// File: rtl/canclk_cfg_reg.sv
module canclk_cfg_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wr_data;
    end

    // R2
    cfg_write_capture_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_q == $past(wr_data)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/canclk_div_stage.sv
module canclk_div_stage
    import canclk_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_en,
    input  logic [CW-1:0] n_cfg,
    output logic          out_en
);
    div_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim_q, lim_d;
    logic          at_end;

    always_comb begin
        at_end = 1'b0;
        unique case (state_q)
            DIV_PASS:  at_end = 1'b1;
            DIV_COUNT: at_end = (cnt_q == lim_q);
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        if (in_en) begin
            if (at_end) begin
                lim_d   = n_cfg;
                cnt_d   = '0;
                state_d = (n_cfg == '0) ? DIV_PASS : DIV_COUNT;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_PASS;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    always_comb begin
        out_en = 1'b0;
        unique case (state_q)
            DIV_PASS:  out_en = in_en;
            DIV_COUNT: out_en = in_en && at_end;
        endcase
    end

    // R6
    div_out_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
        out_en |-> in_en);

    // R3
    div_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q);

    // R7
    div_limit_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> $stable(lim_q));

    // R8
    div_zero_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (lim_q == '0) |-> (out_en == in_en));
endmodule

// File: rtl/canclk_pow2_stage.sv
module canclk_pow2_stage
    import canclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_en,
    input  logic [1:0] sel_cfg,
    output logic       out_en
);
    localparam int CNT_W = 4;

    gt_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = 4'd1;
        unique case (state_q)
            GT_DIV2:  last = 4'd1;
            GT_DIV4:  last = 4'd3;
            GT_DIV8:  last = 4'd7;
            GT_DIV16: last = 4'd15;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (in_en) begin
            if (cnt_q == last) begin
                cnt_d   = '0;
                state_d = gt_state_t'(sel_cfg);
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GT_DIV2;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign out_en = in_en && (cnt_q == last);

    // R6
    gt_out_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
        out_en |-> in_en);

    // R4
    gt_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

    // R7
    gt_mode_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> $stable(state_q));
endmodule

// File: rtl/canclk_chain.sv
module canclk_chain
    import canclk_pkg::*;
#(
    parameter int MEM_W = MEM_DIV_W,
    parameter int SYS_W = SYS_DIV_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [SYS_W+GT_SEL_W+MEM_W-1:0] wr_data,
    output logic                           mem_en,
    output logic                           gt_en,
    output logic                           sys_en
);
    localparam int CFG_W   = SYS_W + GT_SEL_W + MEM_W;
    localparam int SEL_LO  = MEM_W;
    localparam int SYS_LO  = MEM_W + GT_SEL_W;

    logic [CFG_W-1:0] cfg_q;

    canclk_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    canclk_div_stage #(.CW(MEM_W)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .in_en  (1'b1),
        .n_cfg  (cfg_q[MEM_W-1:0]),
        .out_en (mem_en)
    );

    canclk_pow2_stage u_gt (
        .clk     (clk),
        .rst     (rst),
        .in_en   (mem_en),
        .sel_cfg (cfg_q[SEL_LO +: GT_SEL_W]),
        .out_en  (gt_en)
    );

    canclk_div_stage #(.CW(SYS_W)) u_sys (
        .clk    (clk),
        .rst    (rst),
        .in_en  (gt_en),
        .n_cfg  (cfg_q[SYS_LO +: SYS_W]),
        .out_en (sys_en)
    );

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_en && !gt_en && !sys_en));

    // R6
    chain_nesting_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_en |-> gt_en) and (gt_en |-> mem_en));
endmodule

// File: tb/canclk_chain_test.sv
module canclk_chain_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [13:0] wr_data = '0;
    logic        mem_en, gt_en, sys_en;

    int checks = 0;
    int errors = 0;
    int nest_bad = 0;

    always #5 clk = ~clk;

    canclk_chain uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mem_en  (mem_en),
        .gt_en   (gt_en),
        .sys_en  (sys_en)
    );

    // memory divisor, select code, system divisor
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{0, 0, 0},
        '{3, 1, 2},
        '{15, 3, 0},
        '{1, 2, 4},
        '{0, 3, 255},
        '{7, 0, 9}
    };

    function automatic logic [13:0] pack(input int m, input int s, input int y);
        logic [13:0] w;
        w[3:0]  = 4'(m);
        w[5:4]  = 2'(s);
        w[13:6] = 8'(y);
        return w;
    endfunction

    function automatic logic pick(input int which);
        case (which)
            0:       return mem_en;
            1:       return gt_en;
            default: return sys_en;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input int m, input int s, input int y);
        wr_en   = 1'b1;
        wr_data = pack(m, s, y);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(input int which);
        do @(negedge clk); while (!pick(which));
    endtask

    task automatic period_of(input int which, output int p);
        wait_pulse(which);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!pick(which));
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if ((sys_en && !gt_en) || (gt_en && !mem_en))
                nest_bad++;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p;
        int cnt;

        // R1: state right after reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 mem_en first cycle", int'(mem_en), 1);
        check("R1 gt_en first cycle", int'(gt_en), 0);
        @(negedge clk);
        check("R1 mem_en second cycle", int'(mem_en), 1);
        check("R1 gt_en second cycle", int'(gt_en), 1);
        check("R1 sys_en follows gt_en", int'(sys_en), 1);

        // R2 R3 R4 R5: table of configurations
        for (int i = 0; i < NV; i++) begin
            int mp, gp, sp;
            mp = VEC[i][0] + 1;
            gp = mp * (2 << VEC[i][1]);
            sp = gp * (VEC[i][2] + 1);
            do_reset();
            write_cfg(VEC[i][0], VEC[i][1], VEC[i][2]);
            repeat (3) wait_pulse(2);
            period_of(0, p);
            check("R2 R3 memory period", p, mp);
            period_of(1, p);
            check("R4 global timer period", p, gp);
            period_of(2, p);
            check("R5 system tick period", p, sp);
        end

        // R7: reload only at terminal count
        do_reset();
        write_cfg(3, 0, 0);
        repeat (4) wait_pulse(0);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                wr_en   = 1'b1;
                wr_data = pack(1, 0, 0);
            end else begin
                wr_en = 1'b0;
            end
        end while (!mem_en);
        check("R7 current period keeps old length", cnt, 4);
        period_of(0, p);
        check("R7 next period uses new value", p, 2);

        // R8: zero divisors pass pulses through
        do_reset();
        write_cfg(2, 1, 0);
        repeat (3) wait_pulse(2);
        period_of(2, p);
        check("R8 sys equals gt when divisor zero", p, 12);

        // R1: reset in the middle of a run
        do_reset();
        write_cfg(5, 3, 7);
        repeat (40) @(negedge clk);
        do_reset();
        check("R1 mem_en after mid-run reset", int'(mem_en), 1);
        period_of(0, p);
        check("R1 memory period back to one", p, 1);
        period_of(1, p);
        check("R1 global timer back to two", p, 2);

        // R6
        check("R6 nesting violations", nest_bad, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule